// File: doc/BRIEF.md
# Fly-By DMA Controller

This block lets four I/O devices exchange data with memory without the processor copying each word. Software programs each channel with a direction, a first memory address, a word count and a bus-release mode. When a device raises its request line on a programmed channel, the controller asks the processor for the bus. It waits for the grant, then acknowledges the device and runs one strobe sequence per word. The data never passes through the controller. The controller only places the memory address on the bus and pulses one memory strobe and one I/O strobe, so the device and the memory talk to each other directly.

Each word takes four bus clocks. In the first clock the address is put on the bus with no strobe. Two single-clock strobes follow, one after the other. In the last clock the address is still held while the strobes are idle. After each word the channel address goes up by one, wrapping at the address width, and the remaining count goes down by one. In cycle-steal mode the bus goes back to the processor after every word. In burst mode the controller keeps the bus for as long as the device holds its request. When the last word is done, the controller releases the bus and pulses that channel's completion interrupt.

Top module: `fly_dma_ctrl`

## Requirements
- R1: A one-clock write on the programming port loads the selected channel's direction, mode, address and count. Direction 0 means memory to device and direction 1 means device to memory. Mode 0 is cycle-steal and mode 1 is burst. A channel whose count is 0 is disabled, and its request line has no effect.
- R2: The controller arbitrates only while the bus is idle and `hold_ack` is low. Among the requesting channels that are enabled, the lowest-numbered one wins, and `hold_req` goes high on the following clock.
- R3: The controller drives no acknowledge, address or strobe until `hold_ack` is seen high. `hold_req` stays high until the channel releases the bus.
- R4: During each word, only the acknowledge bit of the active channel is high, and it stays high for all four clocks of the word.
- R5: When the direction is memory to device, the word drives the address alone for one clock, then `mem_rd` for one clock, then `io_wr` for one clock, then the address alone again for one clock.
- R6: When the direction is device to memory, the word uses `io_rd` in the second clock and `mem_wr` in the third clock, with the same address framing as R5.
- R7: After each word, the channel address increments and wraps at the address width, and the count decrements.
- R8: After the last word, `hold_req` drops and the channel's bit of `irq` pulses for exactly one clock while the bus is released. The channel is then disabled.
- R9: In cycle-steal mode, the controller releases the bus after every word and arbitrates again before the next word.
- R10: In burst mode, the next word starts straight away while the device still holds its request. If the request has dropped, the controller releases the bus and the channel keeps its remaining count.
- R11: While the bus is taken, a programming write to the active channel is ignored. A write to any other channel takes effect.
- R12: At most one strobe is active at any time, and at most one acknowledge bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Programming write strobe |
| cfg_ch | input | 2 | Channel selected by the write |
| cfg_dir | input | 1 | 0 memory to device, 1 device to memory |
| cfg_burst | input | 1 | 0 cycle-steal, 1 burst |
| cfg_addr | input | 16 | First memory address |
| cfg_count | input | 16 | Number of words, 0 disables |
| dreq | input | 4 | Device request, one per channel |
| hold_ack | input | 1 | Bus grant from processor |
| hold_req | output | 1 | Bus request to processor |
| dack | output | 4 | Device acknowledge, one per channel |
| mem_addr | output | 16 | Memory address, zero when not driving |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| irq | output | 4 | One-clock completion pulse per channel |

## Verification
A behavioural model in the bench predicts every output on every clock. It is driven with the following patterns:
- A cycle-steal channel whose request is held high. This separates per-word release from burst retention.
- A burst channel whose request is held, and another whose request drops partway. These show whether the leftover count survives a release.
- Two requests that arrive in the same clock, to expose the priority order.
- A request on a disabled channel.
- Reprogramming both the active channel and an idle channel during a transfer. This tells the lock apart from a plain write.
- An address that starts at the top of the range, to check the wrap.

The grant latency is varied, so the wait for `hold_ack` cannot be hidden behind a fixed delay.

// File: rtl/fly_dma_pkg.sv
// Package: shared types of the fly-by DMA controller.
// Assumes nothing; holds the sequencer state encoding only.
package fly_dma_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_WAIT  = 3'd1,
        SQ_SETUP = 3'd2,
        SQ_STB1  = 3'd3,
        SQ_STB2  = 3'd4,
        SQ_TAIL  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dma_chan_bank.sv
// Channel bank: one register set per channel (direction, mode, address,
// remaining count). Assumes step is only raised for the active channel
// while busy; writes to the active channel are dropped while busy.
module dma_chan_bank #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int IW  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IW-1:0]            cfg_ch,
    input  logic                     cfg_dir,
    input  logic                     cfg_burst,
    input  logic [AW-1:0]            cfg_addr,
    input  logic [CW-1:0]            cfg_count,
    input  logic                     busy,
    input  logic [IW-1:0]            act_idx,
    input  logic                     step,
    output logic [NCH-1:0][AW-1:0]   ch_addr,
    output logic [NCH-1:0][CW-1:0]   ch_count,
    output logic [NCH-1:0]           ch_dir,
    output logic [NCH-1:0]           ch_burst,
    output logic [NCH-1:0]           ch_armed
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [IW-1:0] MY_ID = IW'(g);
        logic is_act;
        logic wr_ok;
        assign is_act = (act_idx == MY_ID);
        assign wr_ok  = cfg_we && (cfg_ch == MY_ID) && !(busy && is_act);

        // Per-channel registers: advance on a finished word, else accept a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_addr[g]  <= '0;
                ch_count[g] <= '0;
                ch_dir[g]   <= 1'b0;
                ch_burst[g] <= 1'b0;
            end else if (step && is_act) begin
                ch_addr[g]  <= ch_addr[g] + AW'(1);
                ch_count[g] <= ch_count[g] - CW'(1);
            end else if (wr_ok) begin
                ch_addr[g]  <= cfg_addr;
                ch_count[g] <= cfg_count;
                ch_dir[g]   <= cfg_dir;
                ch_burst[g] <= cfg_burst;
            end
        end

        assign ch_armed[g] = (ch_count[g] != '0);
    end
endmodule

// File: rtl/dma_prio_arb.sv
// Fixed-priority arbiter: the lowest-numbered request wins.
// Purely combinational; the caller decides when the result is used.
module dma_prio_arb #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic           gnt_any,
    output logic [IW-1:0]  gnt_idx
);
    // Scan from the top down so the lowest index overwrites the others.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_xfer_seq.sv
// Transfer sequencer: bus takeover handshake and the four-clock word
// frame (setup, strobe 1, strobe 2, tail). Assumes hold_ack stays high
// while hold_req is high once granted.
module dma_xfer_seq
    import fly_dma_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_any,
    input  logic [IW-1:0] gnt_idx,
    input  logic          hold_ack,
    input  logic          act_dreq,
    input  logic          act_burst,
    input  logic          act_last,
    output seq_state_t    state,
    output logic [IW-1:0] act_idx,
    output logic          step,
    output logic          done
);
    seq_state_t st_d;

    // Next-state choice for the takeover and word frame.
    always_comb begin
        st_d = state;
        unique case (state)
            SQ_IDLE:  if (!hold_ack && gnt_any) st_d = SQ_WAIT;
            SQ_WAIT:  if (hold_ack) st_d = SQ_SETUP;
            SQ_SETUP: st_d = SQ_STB1;
            SQ_STB1:  st_d = SQ_STB2;
            SQ_STB2:  st_d = SQ_TAIL;
            SQ_TAIL: begin
                if (act_last)                   st_d = SQ_IDLE;
                else if (act_burst && act_dreq) st_d = SQ_SETUP;
                else                            st_d = SQ_IDLE;
            end
            default:  st_d = SQ_IDLE;
        endcase
    end

    // State register; the winning channel is latched at takeover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            act_idx <= '0;
        end else begin
            state <= st_d;
            if (state == SQ_IDLE && st_d == SQ_WAIT) act_idx <= gnt_idx;
        end
    end

    assign step = (state == SQ_TAIL);
    assign done = step && act_last;
endmodule

// File: rtl/fly_dma_ctrl.sv
// Fly-by DMA controller top: channel bank, arbiter and sequencer,
// plus bus-side decode of strobes, acknowledge, address and interrupts.
// Assumes the processor holds hold_ack while hold_req is high.
module fly_dma_ctrl
    import fly_dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [$clog2(NCH)-1:0] cfg_ch,
    input  logic                   cfg_dir,
    input  logic                   cfg_burst,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [CW-1:0]          cfg_count,
    input  logic [NCH-1:0]         dreq,
    input  logic                   hold_ack,
    output logic                   hold_req,
    output logic [NCH-1:0]         dack,
    output logic [AW-1:0]          mem_addr,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic                   io_rd,
    output logic                   io_wr,
    output logic [NCH-1:0]         irq
);
    localparam int IW = $clog2(NCH);

    logic [NCH-1:0][AW-1:0] ch_addr;
    logic [NCH-1:0][CW-1:0] ch_count;
    logic [NCH-1:0]         ch_dir, ch_burst, ch_armed;
    logic                   gnt_any, step, done, busy, on_bus;
    logic [IW-1:0]          gnt_idx, act_idx;
    seq_state_t             state;
    logic [NCH-1:0]         irq_q;

    assign busy = (state != SQ_IDLE);

    dma_chan_bank #(.NCH(NCH), .AW(AW), .CW(CW), .IW(IW)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_dir(cfg_dir), .cfg_burst(cfg_burst), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .busy(busy), .act_idx(act_idx), .step(step),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_dir(ch_dir),
        .ch_burst(ch_burst), .ch_armed(ch_armed)
    );

    dma_prio_arb #(.NCH(NCH), .IW(IW)) u_arb (
        .req(dreq & ch_armed), .gnt_any(gnt_any), .gnt_idx(gnt_idx)
    );

    dma_xfer_seq #(.IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
        .hold_ack(hold_ack), .act_dreq(dreq[act_idx]),
        .act_burst(ch_burst[act_idx]),
        .act_last(ch_count[act_idx] == CW'(1)),
        .state(state), .act_idx(act_idx), .step(step), .done(done)
    );

    // Bus-side decode of the word frame.
    assign on_bus   = (state == SQ_SETUP) || (state == SQ_STB1) ||
                      (state == SQ_STB2)  || (state == SQ_TAIL);
    assign hold_req = busy;
    assign dack     = on_bus ? (NCH'(1) << act_idx) : '0;
    assign mem_addr = on_bus ? ch_addr[act_idx] : '0;
    assign mem_rd   = (state == SQ_STB1) && !ch_dir[act_idx];
    assign io_rd    = (state == SQ_STB1) &&  ch_dir[act_idx];
    assign io_wr    = (state == SQ_STB2) && !ch_dir[act_idx];
    assign mem_wr   = (state == SQ_STB2) &&  ch_dir[act_idx];

    // Completion pulse, one clock after the last word's tail.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= done ? (NCH'(1) << act_idx) : '0;
    end
    assign irq = irq_q;
endmodule

// File: rtl/fly_dma_ctrl_sva.sv
// Checker for the fly-by DMA controller's bus-side protocol, bound to
// the top module. Observes ports only.
module fly_dma_ctrl_sva #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_ack,
    input logic           hold_req,
    input logic [NCH-1:0] dack,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic [NCH-1:0] irq
);
    logic any_stb;
    assign any_stb = mem_rd | mem_wr | io_rd | io_wr;

    p_dack_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |-> (hold_ack && hold_req));
    p_strobe_needs_dack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> (dack != '0));
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> $stable(mem_addr));
    p_addr_held_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr | io_wr) |=> ($stable(mem_addr) && $stable(dack) && !any_stb));
    p_memrd_then_iowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> io_wr);
    p_iord_then_memwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> mem_wr);
    p_irq_bus_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> (!hold_req && $countones(irq) == 1));
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |=> (irq == '0));
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
    p_one_dack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));
endmodule

bind fly_dma_ctrl fly_dma_ctrl_sva #(.NCH(NCH), .AW(AW), .CW(CW)) u_sva (.*);

// File: tb/fly_dma_ctrl_tb.sv
module fly_dma_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic        cfg_dir = 1'b0, cfg_burst = 1'b0;
    logic [15:0] cfg_addr = '0, cfg_count = '0;
    logic [3:0]  dreq = '0;
    logic        hold_ack = 1'b0;
    logic        hold_req, mem_rd, mem_wr, io_rd, io_wr;
    logic [3:0]  dack, irq;
    logic [15:0] mem_addr;

    int checks = 0, fails = 0;
    int ack_lat = 1, ack_wait = 0;
    int rises = 0, wr_pulses = 0, first_irq = -1;
    logic prev_hr = 1'b0;
    logic [15:0] last_wr_addr = '0;

    // Reference model state
    int          m_st = 0, m_act = 0;
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt [4];
    logic        m_dir [4];
    logic        m_burst [4];
    logic [3:0]  m_irq = '0;

    fly_dma_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_dir(cfg_dir), .cfg_burst(cfg_burst), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .dreq(dreq), .hold_ack(hold_ack),
        .hold_req(hold_req), .dack(dack), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        logic [3:0] nirq;
        int sel;
        if (!rst_n) begin
            m_st = 0; m_act = 0; m_irq = '0;
            for (int i = 0; i < 4; i++) begin
                m_addr[i] = '0; m_cnt[i] = '0; m_dir[i] = 0; m_burst[i] = 0;
            end
        end else begin
            nirq = '0;
            sel = -1;
            if (m_st == 0) begin
                if (!hold_ack)
                    for (int i = 3; i >= 0; i--)
                        if (dreq[i] && m_cnt[i] != 0) sel = i;
                if (sel >= 0) begin m_act = sel; m_st = 1; end
            end else if (m_st == 1) begin
                if (hold_ack) m_st = 2;
            end else if (m_st < 5) begin
                m_st = m_st + 1;
            end else begin
                m_addr[m_act] = m_addr[m_act] + 16'd1;
                m_cnt[m_act]  = m_cnt[m_act] - 16'd1;
                if (m_cnt[m_act] == 0) begin
                    nirq[m_act] = 1'b1; m_st = 0;
                end else if (m_burst[m_act] && dreq[m_act]) m_st = 2;
                else m_st = 0;
            end
            if (cfg_we && !(m_st_before_busy(cfg_ch))) begin
                m_addr[cfg_ch] = cfg_addr; m_cnt[cfg_ch] = cfg_count;
                m_dir[cfg_ch] = cfg_dir;   m_burst[cfg_ch] = cfg_burst;
            end
            m_irq = nirq;
        end
    end

    // Lock test uses the state held before this edge's update.
    int m_prev_st = 0, m_prev_act = 0;
    always @(negedge clk) begin m_prev_st = m_st; m_prev_act = m_act; end
    function automatic bit m_st_before_busy(input logic [1:0] ch);
        return (m_prev_st != 0) && (int'(ch) == m_prev_act);
    endfunction

    // Processor side: grant after ack_lat clocks, drop when request falls.
    always @(negedge clk) begin
        if (!hold_req) begin hold_ack = 1'b0; ack_wait = 0; end
        else if (!hold_ack) begin
            ack_wait++;
            if (ack_wait >= ack_lat) hold_ack = 1'b1;
        end
    end

    // Per-clock comparison against the model, plus event counters.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0]  e_dack;
            logic [15:0] e_addr;
            bit on;
            on = (m_st >= 2);
            e_dack = on ? (4'd1 << m_act) : 4'd0;
            e_addr = on ? m_addr[m_act] : 16'd0;
            chk(hold_req == (m_st != 0), "R2 R3 hold_req", hold_req, m_st != 0);
            chk(dack == e_dack, "R4 dack", dack, e_dack);
            chk(mem_addr == e_addr, "R7 mem_addr", mem_addr, e_addr);
            chk(mem_rd == (m_st == 3 && !m_dir[m_act]), "R5 mem_rd", mem_rd, m_st == 3 && !m_dir[m_act]);
            chk(io_wr == (m_st == 4 && !m_dir[m_act]), "R5 io_wr", io_wr, m_st == 4 && !m_dir[m_act]);
            chk(io_rd == (m_st == 3 && m_dir[m_act]), "R6 io_rd", io_rd, m_st == 3 && m_dir[m_act]);
            chk(mem_wr == (m_st == 4 && m_dir[m_act]), "R6 mem_wr", mem_wr, m_st == 4 && m_dir[m_act]);
            chk(irq == m_irq, "R8 irq", irq, m_irq);
            chk($countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1, "R12 strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
            if (hold_req && !prev_hr) rises++;
            if (io_wr || mem_wr) begin wr_pulses++; last_wr_addr = mem_addr; end
            if (irq != 0 && first_irq < 0)
                for (int i = 0; i < 4; i++) if (irq[i]) first_irq = i;
        end
        prev_hr = hold_req;
    end

    task automatic prog(input int ch, input bit dir, input bit bst, input int a, input int n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_dir = dir; cfg_burst = bst;
        cfg_addr = 16'(a); cfg_count = 16'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq(input int ch);
        int n = 0;
        while (!irq[ch] && n < 3000) begin @(negedge clk); n++; end
        chk(n < 3000, "R8 irq timeout", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: bus untouched (R3)
        chk(!hold_req && dack == 0 && mem_addr == 0 && irq == 0, "R3 reset",
            {hold_req, dack, irq}, 0);

        // R5, R9: cycle-steal memory to device, request held
        prog(2, 0, 0, 16'h0100, 3);
        rises = 0; dreq[2] = 1'b1;
        wait_irq(2);
        dreq[2] = 1'b0;
        chk(rises == 3, "R9 one takeover per word", rises, 3);
        repeat (3) @(negedge clk);

        // R6, R10: burst device to memory, request held
        ack_lat = 3;
        prog(1, 1, 1, 16'h2000, 4);
        rises = 0; dreq[1] = 1'b1;
        wait_irq(1);
        dreq[1] = 1'b0;
        chk(rises == 1, "R10 single takeover in burst", rises, 1);
        repeat (3) @(negedge clk);

        // R10: burst with request dropped partway
        ack_lat = 1;
        prog(1, 1, 1, 16'h3000, 5);
        rises = 0; dreq[1] = 1'b1;
        repeat (9) @(negedge clk);
        dreq[1] = 1'b0;
        repeat (10) @(negedge clk);
        dreq[1] = 1'b1;
        wait_irq(1);
        dreq[1] = 1'b0;
        chk(rises >= 2, "R10 release on dropped request", rises, 2);
        repeat (3) @(negedge clk);

        // R2: simultaneous requests, lowest index first
        prog(3, 0, 0, 16'h0300, 2);
        prog(0, 1, 0, 16'h0000, 2);
        first_irq = -1;
        dreq = 4'b1001;
        wait_irq(3);
        dreq = 4'b0000;
        chk(first_irq == 0, "R2 priority", first_irq, 0);
        repeat (3) @(negedge clk);

        // R1: disabled channel ignores its request
        prog(2, 0, 0, 16'h0050, 0);
        dreq[2] = 1'b1;
        repeat (6) @(negedge clk);
        chk(!hold_req && dack == 0, "R1 disabled channel", hold_req, 0);
        dreq[2] = 1'b0;

        // R11: write to active channel ignored, other channel accepted
        ack_lat = 2;
        prog(1, 0, 1, 16'h0400, 3);
        dreq[1] = 1'b1;
        while (dack == 0) @(negedge clk);
        wr_pulses = 0;
        prog(1, 1, 0, 16'h0900, 7);
        prog(3, 1, 0, 16'h0700, 1);
        wait_irq(1);
        dreq[1] = 1'b0;
        chk(wr_pulses == 3, "R11 active channel locked", wr_pulses, 3);
        dreq[3] = 1'b1;
        wait_irq(3);
        dreq[3] = 1'b0;
        chk(last_wr_addr == 16'h0700, "R11 idle channel written", last_wr_addr, 16'h0700);

        // R7: address wrap at the top of the range
        prog(0, 1, 1, 16'hFFFF, 2);
        dreq[0] = 1'b1;
        wait_irq(0);
        dreq[0] = 1'b0;
        chk(last_wr_addr == 16'h0000, "R7 address wrap", last_wr_addr, 0);
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule